// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Controller

This block chooses which way of a set-associative cache or translation buffer to replace. It keeps a binary-tree pseudo-LRU word for every set in a small state RAM. One combinational tree unit serves every set: it picks the victim way and computes the updated tree word. Each access is presented in two steps. In the tag-match cycle the cache offers the set index. In the following cycle it reports either a hit, with the way that hit, or the start of a miss. During that second cycle the state word is read asynchronously, and it is written back at the end of the same cycle.

A hit marks the hit way as most recently used. A miss walks the tree to find a victim and latches it on the victim output, where it stays until the next miss. The same write also marks that victim as used, so the next miss to the set picks a different way. The write-port signals of the state RAM are brought out so that the surrounding cache can observe every state change.

Top module: `tplru_ctrl`

## Requirements
- R1: During and after reset the victim output is 0, no state write is issued, and every set's state reads as all zeros, so the first miss in any set selects way 0.
- R2: A hit in the cycle after a valid lookup issues a write in that same cycle, to the looked-up set. The written word is the old word with the hit way marked most recently used. Encoding: node k (k = 1..WAYS-1) is bit k-1 of the word, its children are nodes 2k and 2k+1, and a node bit of 0 points the victim search at child 2k (lower way numbers). Marking way w sets every node on w's path to point away from w.
- R3: A miss in the cycle after a valid lookup computes the victim by walking from node 1, taking child 2k+b where b is the node's bit. The chosen bits, root first, form the way number from MSB down. The victim appears on the victim output after the next clock edge.
- R4: A miss also writes the set's word with the victim marked used, in the same cycle. With 4 ways, consecutive misses to a fresh set give ways 0, 2, 1, 3.
- R5: A word written in one cycle is the word seen by a lookup of the same set processed in the next cycle, so back-to-back misses to one set never repeat a way until every way has been chosen.
- R6: Hit and miss indications are ignored when no valid lookup was offered in the previous cycle: no write occurs and the victim output does not change.
- R7: When hit and miss are both asserted, the hit is handled and the miss is ignored: the victim output keeps its value.
- R8: Sets are independent; accesses to one set never alter the victim sequence of another.
- R9: With a single way the victim output is always 0.
- R10: The victim output changes only at the clock edge that ends a handled miss cycle; otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_valid_i | input | 1 | Lookup offered in this (tag-match) cycle |
| acc_set_i | input | log2(SETS) | Set index of the lookup |
| hit_i | input | 1 | Previous cycle's lookup hit |
| hit_way_i | input | log2(WAYS), min 1 | Way that hit |
| miss_i | input | 1 | Previous cycle's lookup missed; start miss handling |
| victim_o | output | log2(WAYS), min 1 | Latched victim way of the last miss |
| ram_we_o | output | 1 | State RAM write enable |
| ram_waddr_o | output | log2(SETS) | State RAM write address |
| ram_wdata_o | output | max(WAYS-1,1) | State RAM write data (tree word) |

## Verification
The hardest case to reach from the ports is a lookup that reads a word written in the cycle just before. This needs a hit or miss in one cycle and a lookup of the same set in the same cycle, so that its result is handled in the very next cycle. The stimulus issues runs of back-to-back misses and mixed hits to one set, with a new lookup offered every cycle, and checks the 0, 2, 1, 3 victim order. A long pseudo-random phase then mixes sets, idle cycles, stray hit/miss pulses and simultaneous hit and miss. A behavioural model that keeps each set's tree as a flat node list compares every cycle.

// File: rtl/tplru_pkg.sv
package tplru_pkg;
  // Width of a way number; at least one bit so a single way still has a port.
  function automatic int way_w(input int ways);
    return (ways > 1) ? $clog2(ways) : 1;
  endfunction

  // Tree node count; a single-way cache keeps one dummy bit.
  function automatic int node_w(input int ways);
    return (ways > 1) ? ways - 1 : 1;
  endfunction
endpackage

// File: rtl/tplru_state_ram.sv
module tplru_state_ram #(
  parameter  int ENTRIES = 16,
  parameter  int WIDTH   = 3,
  localparam int AW      = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // Asynchronous read port
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tplru_tree.sv
module tplru_tree #(
  parameter  int WAYS  = 4,
  localparam int WAY_W = tplru_pkg::way_w(WAYS),
  localparam int NODES = tplru_pkg::node_w(WAYS)
) (
  input  logic [NODES-1:0] state_i,
  input  logic             use_hit_i,
  input  logic [WAY_W-1:0] hit_way_i,
  output logic [WAY_W-1:0] victim_o,
  output logic [NODES-1:0] next_o
);
  generate
    if (WAYS == 1) begin : g_single
      logic unused_in;
      assign unused_in = ^{use_hit_i, hit_way_i};
      assign victim_o  = '0;
      assign next_o    = state_i;
    end else begin : g_tree
      localparam int LEVELS = $clog2(WAYS);
      logic [WAY_W-1:0] touch;

      // Walk from the root; each node bit picks the child to descend into.
      always_comb begin
        int node;
        victim_o = '0;
        node     = 1;
        for (int l = 0; l < LEVELS; l++) begin
          victim_o[LEVELS-1-l] = state_i[node-1];
          node = 2 * node + int'(state_i[node-1]);
        end
      end

      assign touch = use_hit_i ? hit_way_i : victim_o;

      // Point every node on the touched way's path away from it.
      always_comb begin
        int node;
        next_o = state_i;
        node   = 1;
        for (int l = 0; l < LEVELS; l++) begin
          next_o[node-1] = ~touch[LEVELS-1-l];
          node = 2 * node + int'(touch[LEVELS-1-l]);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tplru_ctrl.sv
module tplru_ctrl #(
  parameter  int SETS  = 16,
  parameter  int WAYS  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = tplru_pkg::way_w(WAYS),
  localparam int NODES = tplru_pkg::node_w(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid_i,
  input  logic [SET_W-1:0] acc_set_i,
  input  logic             hit_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic             miss_i,
  output logic [WAY_W-1:0] victim_o,
  output logic             ram_we_o,
  output logic [SET_W-1:0] ram_waddr_o,
  output logic [NODES-1:0] ram_wdata_o
);
  logic             s_valid;
  logic [SET_W-1:0] s_set;
  logic [NODES-1:0] rd_state;
  logic [NODES-1:0] nxt_state;
  logic [WAY_W-1:0] walk_way;
  logic [WAY_W-1:0] victim_q, victim_d;
  logic             hit_go, miss_go;

  // Stage register: set index held for the cycle after tag match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_set   <= '0;
    end else begin
      s_valid <= acc_valid_i;
      if (acc_valid_i) s_set <= acc_set_i;
    end
  end

  // Hit has priority over miss
  always_comb begin
    hit_go  = s_valid & hit_i;
    miss_go = s_valid & miss_i & ~hit_i;
  end

  tplru_state_ram #(
    .ENTRIES (SETS),
    .WIDTH   (NODES)
  ) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ram_we_o),
    .waddr_i (ram_waddr_o),
    .wdata_i (ram_wdata_o),
    .raddr_i (s_set),
    .rdata_o (rd_state)
  );

  tplru_tree #(
    .WAYS      (WAYS)
  ) u_tree (
    .state_i   (rd_state),
    .use_hit_i (hit_go),
    .hit_way_i (hit_way_i),
    .victim_o  (walk_way),
    .next_o    (nxt_state)
  );

  assign ram_we_o    = hit_go | miss_go;
  assign ram_waddr_o = s_set;
  assign ram_wdata_o = nxt_state;

  // Victim latch: next-state and register kept apart
  always_comb begin
    victim_d = victim_q;
    if (miss_go) victim_d = walk_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) victim_q <= '0;
    else        victim_q <= victim_d;
  end

  assign victim_o = victim_q;
endmodule

// File: rtl/tplru_ctrl_chk.sv
module tplru_ctrl_chk #(
  parameter  int SETS  = 16,
  parameter  int WAYS  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = tplru_pkg::way_w(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid_i,
  input logic [SET_W-1:0] acc_set_i,
  input logic             hit_i,
  input logic             miss_i,
  input logic [WAY_W-1:0] victim_o,
  input logic             ram_we_o,
  input logic [SET_W-1:0] ram_waddr_o,
  input logic             s_valid
);
  p_write_needs_lookup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> $past(acc_valid_i));

  p_write_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> (ram_waddr_o == $past(acc_set_i)));

  p_hit_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && hit_i) |-> ram_we_o);

  p_miss_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && miss_i) |-> ram_we_o);

  p_victim_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && miss_i && !hit_i) |=> $stable(victim_o));

  p_hit_keeps_victim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && hit_i) |=> $stable(victim_o));

  always @(posedge clk) begin
    if (rst_n && WAYS == 1) begin
      p_single_way_r9: assert (victim_o == '0);
    end
  end
endmodule

bind tplru_ctrl tplru_ctrl_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid_i (acc_valid_i),
  .acc_set_i   (acc_set_i),
  .hit_i       (hit_i),
  .miss_i      (miss_i),
  .victim_o    (victim_o),
  .ram_we_o    (ram_we_o),
  .ram_waddr_o (ram_waddr_o),
  .s_valid     (s_valid)
);

// File: tb/tplru_ctrl_tb.sv
module tplru_ctrl_tb;
  localparam int SETS = 16;
  localparam int WAYS = 4;
  localparam int LV   = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_valid;
  logic [3:0] acc_set;
  logic       hit;
  logic [1:0] hit_way;
  logic       miss;
  logic [1:0] victim;
  logic       we;
  logic [3:0] waddr;
  logic [2:0] wdata;
  logic [0:0] victim1;
  logic       we1;
  logic [1:0] waddr1;
  logic [0:0] wdata1;

  always #4 clk = ~clk;  // 125 MHz

  tplru_ctrl #(.SETS(SETS), .WAYS(WAYS)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid), .acc_set_i(acc_set),
    .hit_i(hit), .hit_way_i(hit_way), .miss_i(miss), .victim_o(victim),
    .ram_we_o(we), .ram_waddr_o(waddr), .ram_wdata_o(wdata));

  tplru_ctrl #(.SETS(4), .WAYS(1)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid), .acc_set_i(acc_set[1:0]),
    .hit_i(hit), .hit_way_i(1'b0), .miss_i(miss), .victim_o(victim1),
    .ram_we_o(we1), .ram_waddr_o(waddr1), .ram_wdata_o(wdata1));

  int total = 0;
  int fails = 0;
  bit done  = 0;

  // Reference model: per-set node list, indexed by node number 1..3
  bit m_node [SETS][1:3];
  bit m_sv;
  int m_sset;
  int m_vic;

  function automatic int path_node(int w, int l);
    return (1 << l) + (w >> (LV - l));
  endfunction

  function automatic int path_dir(int w, int l);
    return (w >> (LV - 1 - l)) & 1;
  endfunction

  // Victim: the only way whose whole path agrees with the node bits
  function automatic int model_victim(int s);
    for (int w = 0; w < WAYS; w++) begin
      bit ok = 1;
      for (int l = 0; l < LV; l++)
        if (int'(m_node[s][path_node(w, l)]) != path_dir(w, l)) ok = 0;
      if (ok) return w;
    end
    return -1;
  endfunction

  function automatic int model_word_after(int s, int w);
    int word = 0;
    bit tmp [1:3];
    for (int n = 1; n <= 3; n++) tmp[n] = m_node[s][n];
    for (int l = 0; l < LV; l++) tmp[path_node(w, l)] = ~path_dir(w, l);
    for (int n = 1; n <= 3; n++) word |= int'(tmp[n]) << (n - 1);
    return word;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit av, input int aset, input bit h, input int hw,
                      input bit m, input string req);
    bit hg, mg;
    int vw, ew;
    @(negedge clk);
    acc_valid = av; acc_set = 4'(aset); hit = h; hit_way = 2'(hw); miss = m;
    #1;
    hg = m_sv && h;
    mg = m_sv && m && !h;
    chk(we == (hg || mg), {req, " write enable"}, int'(we), int'(hg || mg));
    chk(int'(victim) == m_vic, {req, " victim hold"}, int'(victim), m_vic);
    chk(victim1 == 1'b0, "R9 single way victim", int'(victim1), 0);
    if (hg || mg) begin
      vw = hg ? hw : model_victim(m_sset);
      ew = model_word_after(m_sset, vw);
      chk(int'(waddr) == m_sset, {req, " write address"}, int'(waddr), m_sset);
      chk(int'(wdata) == ew, {req, " write data"}, int'(wdata), ew);
      for (int l = 0; l < LV; l++) m_node[m_sset][path_node(vw, l)] = ~path_dir(vw, l);
      if (mg) m_vic = vw;
    end
    m_sv = av;
    if (av) m_sset = aset;
  endtask

  // Checks the victim output just after the edge that ends the current cycle
  task automatic chk_vic(input int exp, input string req);
    @(posedge clk);
    #2;
    chk(int'(victim) == exp, req, int'(victim), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int seed = 7;
    for (int s = 0; s < SETS; s++) for (int n = 1; n <= 3; n++) m_node[s][n] = 0;
    m_sv = 0; m_sset = 0; m_vic = 0;
    rst_n = 1'b0; acc_valid = 0; acc_set = 0; hit = 0; hit_way = 0; miss = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(victim == 2'd0, "R1 reset victim", int'(victim), 0);
    chk(we == 1'b0, "R1 reset write", int'(we), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R4/R5: back-to-back misses to set 5 give 0,2,1,3
    step(1, 5, 0, 0, 0, "R1");
    step(1, 5, 0, 0, 1, "R4"); chk_vic(0, "R1 first victim is way 0");
    step(1, 5, 0, 0, 1, "R5"); chk_vic(2, "R4 second victim");
    step(1, 5, 0, 0, 1, "R5"); chk_vic(1, "R5 third victim");
    step(0, 0, 0, 0, 1, "R3"); chk_vic(3, "R3 fourth victim");

    // R8: a fresh set starts at way 0
    step(1, 9, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 1, "R8"); chk_vic(0, "R8 independent set");

    // R2: hit way 3 then miss picks way 0; hit way 0 then miss picks 2
    step(1, 2, 0, 0, 0, "R2");
    step(1, 2, 1, 3, 0, "R2");
    step(0, 0, 0, 0, 1, "R2"); chk_vic(0, "R2 miss after hit way 3");
    step(1, 2, 0, 0, 0, "R2");
    step(1, 2, 1, 0, 0, "R2");
    step(0, 0, 0, 0, 1, "R2"); chk_vic(2, "R2 miss after hit way 0");

    // R6: hit/miss without a preceding lookup are ignored
    step(0, 2, 0, 0, 0, "R6");
    step(0, 2, 1, 1, 0, "R6");
    step(0, 2, 0, 0, 1, "R6"); chk_vic(2, "R6 stray miss ignored");
    step(1, 2, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 1, "R6"); chk_vic(1, "R6 state untouched by stray pulses");

    // R7: simultaneous hit and miss, hit wins
    step(1, 7, 0, 0, 0, "R7");
    step(0, 0, 1, 2, 1, "R7"); chk_vic(1, "R7 hit priority keeps victim");

    // R10: idle cycles hold the victim
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, "R10");
    chk_vic(1, "R10 victim held while idle");

    // R3: pseudo-random mix
    for (int i = 0; i < 400; i++) begin
      seed = seed * 1103515245 + 12345;
      step(seed[16], int'(seed[20:18]), seed[22] & seed[23], int'(seed[25:24]),
           seed[27], "R3");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule